// File: doc/BRIEF.md
# Quadrature Up/Down Counter with Coherent Snapshot Latch

This block turns two quadrature phase signals into position steps and keeps an up/down count of them. Every edge on either phase is one step, so one full phase cycle gives four counts. The direction of each step follows from which phase leads. The running count is not visible directly. An active-low strobe copies it into a snapshot register, which drives the count output. Carry and borrow pulses mark wrap-around, so wider positions can be built from several counters.

The phase inputs and the strobe may change at any time relative to the system clock. Each goes through a two-flop synchronizer. A strobe request that arrives while a step is being applied, or within a settling window of `SETTLE_CYC` cycles after it, is held in a set/reset element. The request is then served once the count is quiet. The snapshot is therefore always a value the count really held, either the one before the step or the one after it. A sampled change of both phases at once is not a legal step. It is ignored and sets a sticky error flag.

Top module: `quad_latch_counter`

## Requirements
- R1: Each single-phase change of the synchronized inputs produces exactly one count step, giving four steps per full phase cycle. A sample with no phase change leaves the count unchanged.
- R2: Writing the phase pair as {A,B}, the order 00, 10, 11, 01, 00 (A leads) counts up and the reverse order counts down.
- R3: When both phases change in the same sample, the count is unchanged and `phase_err` goes to 1. It stays at 1 until reset.
- R4: Counting up from 255 gives 0, with `carry_out` high for exactly one cycle.
- R5: Counting down from 0 gives 255, with `borrow_out` high for exactly one cycle.
- R6: `dir_up` is 1 after an up step and 0 after a down step, and it holds between steps. Reset sets it to 1.
- R7: While `strobe_n` is high and no request is pending, `snap_count` holds its value. While `strobe_n` is low and the count is quiet, `snap_count` follows the count.
- R8: No capture happens in the cycle of a step or within `SETTLE_CYC` cycles after it. Every value shown on `snap_count` is a value the count actually held.
- R9: A falling edge of the strobe during a busy window is remembered. The capture is made as soon as the window ends, even if the strobe has gone high again by then.
- R10: A phase change at the inputs reaches the count, `dir_up`, `carry_out` and `borrow_out` on the third rising clock edge after it is first sampled.
- R11: A synchronous active-high `rst` clears the count, the snapshot, `phase_err` and any pending request, and sets `dir_up` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_a | input | 1 | Phase A, asynchronous |
| quad_b | input | 1 | Phase B, asynchronous |
| strobe_n | input | 1 | Active-low snapshot request, asynchronous |
| snap_count | output | CNT_W | Snapshot of the count |
| dir_up | output | 1 | Direction of the last step, 1 means up |
| carry_out | output | 1 | One-cycle pulse on an up wrap |
| borrow_out | output | 1 | One-cycle pulse on a down wrap |
| phase_err | output | 1 | Sticky flag for an illegal double phase change |

## Verification
The running count is internal, so a wrong step or wrong direction shows up first on `dir_up` three edges after the phase change. It reaches `snap_count` only at the next quiet capture, `SETTLE_CYC` plus one cycles after the step at the earliest. A stuck pending flag or a wrong settling counter shows up as a snapshot that arrives a cycle early or late, or that never arrives. The bench catches this because it compares every port with a cycle model on every clock. It also checks every new snapshot against the set of counts that really existed, which catches a torn value.

// File: rtl/qlc_pkg.sv
package qlc_pkg;

  typedef enum logic [1:0] {
    QS_IDLE = 2'd0,
    QS_UP   = 2'd1,
    QS_DOWN = 2'd2,
    QS_BAD  = 2'd3
  } qstep_e;

  // Classify one sample-to-sample move of the phase pair {A,B}.
  function automatic qstep_e qlc_classify(input logic [1:0] prev_ab,
                                          input logic [1:0] cur_ab);
    logic [1:0] chg;
    qstep_e     kind;
    chg = prev_ab ^ cur_ab;
    case (chg)
      2'b00:   kind = QS_IDLE;
      2'b11:   kind = QS_BAD;
      2'b10:   kind = (cur_ab[1] != cur_ab[0]) ? QS_UP : QS_DOWN;
      default: kind = (cur_ab[1] == cur_ab[0]) ? QS_UP : QS_DOWN;
    endcase
    return kind;
  endfunction

endpackage

// File: rtl/qlc_sync.sv
module qlc_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;

endmodule

// File: rtl/qlc_phase_decode.sv
module qlc_phase_decode
  import qlc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_s,
  input  logic b_s,
  output logic step_up,
  output logic step_dn,
  output logic step_bad,
  output logic phase_err
);

  logic [1:0] prev_ab;
  qstep_e     kind;

  always_ff @(posedge clk) begin
    if (rst) prev_ab <= 2'b00;
    else     prev_ab <= {a_s, b_s};
  end

  assign kind     = qlc_classify(prev_ab, {a_s, b_s});
  assign step_up  = (kind == QS_UP);
  assign step_dn  = (kind == QS_DOWN);
  assign step_bad = (kind == QS_BAD);

  always_ff @(posedge clk) begin
    if (rst)           phase_err <= 1'b0;
    else if (step_bad) phase_err <= 1'b1;
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({step_up, step_dn, step_bad})); // R1

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    phase_err |=> phase_err); // R3

  AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (rst)
    step_bad |=> phase_err); // R3

endmodule

// File: rtl/qlc_updown.sv
module qlc_updown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             carry,
  output logic             borrow,
  output logic             dir_up
);

  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE_VAL = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      carry  <= 1'b0;
      borrow <= 1'b0;
      dir_up <= 1'b1;
    end else begin
      carry  <= inc && (count == TOP_VAL);
      borrow <= dec && (count == '0);
      if (inc) begin
        count  <= count + ONE_VAL;
        dir_up <= 1'b1;
      end else if (dec) begin
        count  <= count - ONE_VAL;
        dir_up <= 1'b0;
      end
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!inc && !dec) |=> $stable(count)); // R1

  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst)
    carry |-> (count == '0)); // R4

  AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    carry |=> !carry); // R4

  AST_BORROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    borrow |-> (count == TOP_VAL)); // R5

  AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    dec |=> !dir_up); // R6

endmodule

// File: rtl/qlc_strobe_ctl.sv
module qlc_strobe_ctl #(
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_n_s,
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] snap,
  output logic             lat_en,
  output logic             pend
);

  localparam int SW = $clog2(SETTLE_CYC + 2);
  localparam logic [SW-1:0] SETTLE_LD = SW'(SETTLE_CYC);

  logic          stb_prev;
  logic [SW-1:0] settle_cnt;
  logic          busy;
  logic          stb_fall;

  assign busy     = step || (settle_cnt != '0);
  assign stb_fall = stb_prev && !stb_n_s;
  assign lat_en   = (pend || !stb_n_s) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev   <= 1'b1;
      settle_cnt <= '0;
      pend       <= 1'b0;
      snap       <= '0;
    end else begin
      stb_prev <= stb_n_s;
      if (step)                  settle_cnt <= SETTLE_LD;
      else if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
      pend <= (pend || stb_fall) && !lat_en;
      if (lat_en) snap <= count;
    end
  end

  AST_NO_CAPTURE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> $stable(snap)); // R8

  AST_PEND_WAITS: assert property (@(posedge clk) disable iff (rst)
    (pend && step) |=> pend); // R9

endmodule

// File: rtl/quad_latch_counter.sv
module quad_latch_counter #(
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             quad_a,
  input  logic             quad_b,
  input  logic             strobe_n,
  output logic [CNT_W-1:0] snap_count,
  output logic             dir_up,
  output logic             carry_out,
  output logic             borrow_out,
  output logic             phase_err
);

  logic [2:0]       raw_in;
  logic [2:0]       sync_in;
  logic             a_s;
  logic             b_s;
  logic             stb_n_s;
  logic             step_up;
  logic             step_dn;
  logic             step_bad;
  logic             step_any;
  logic [CNT_W-1:0] count;
  logic             lat_en;
  logic             pend;

  assign raw_in = {strobe_n, quad_a, quad_b};

  qlc_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .q_sync  (sync_in)
  );

  assign stb_n_s = sync_in[2];
  assign a_s     = sync_in[1];
  assign b_s     = sync_in[0];

  qlc_phase_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .a_s       (a_s),
    .b_s       (b_s),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .step_bad  (step_bad),
    .phase_err (phase_err)
  );

  assign step_any = step_up || step_dn;

  qlc_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc    (step_up),
    .dec    (step_dn),
    .count  (count),
    .carry  (carry_out),
    .borrow (borrow_out),
    .dir_up (dir_up)
  );

  qlc_strobe_ctl #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_stb (
    .clk     (clk),
    .rst     (rst),
    .stb_n_s (stb_n_s),
    .step    (step_any),
    .count   (count),
    .snap    (snap_count),
    .lat_en  (lat_en),
    .pend    (pend)
  );

  AST_SNAP_FROM_COUNT: assert property (@(posedge clk) disable iff (rst)
    (snap_count != $past(snap_count)) |-> (snap_count == $past(count))); // R7

  AST_BAD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    step_bad |=> $stable(count)); // R3

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stb_n_s && !pend) |=> $stable(snap_count)); // R7

endmodule

// File: tb/quad_latch_counter_test.sv
module quad_latch_counter_test;

  localparam int CW     = 8;
  localparam int SETTLE = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          qa;
  logic          qb;
  logic          stbn;
  logic [CW-1:0] snap;
  logic          dir;
  logic          carry;
  logic          borrow;
  logic          perr;

  int n_checks = 0;
  int n_errors = 0;

  quad_latch_counter #(.CNT_W(CW), .SETTLE_CYC(SETTLE)) uut (
    .clk        (clk),
    .rst        (rst),
    .quad_a     (qa),
    .quad_b     (qb),
    .strobe_n   (stbn),
    .snap_count (snap),
    .dir_up     (dir),
    .carry_out  (carry),
    .borrow_out (borrow),
    .phase_err  (perr)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0] hist[$];
  int  m_cnt, m_snap, m_settle;
  bit  m_pend, m_dir, m_carry, m_borrow, m_err;
  bit  seen[int];
  bit  carry_seen, borrow_seen;

  function automatic int ph_index(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < 3; i++) hist.push_back(3'b100);
    m_cnt = 0; m_snap = 0; m_settle = 0;
    m_pend = 0; m_dir = 1; m_carry = 0; m_borrow = 0; m_err = 0;
    seen.delete();
    seen[0] = 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      int  d;
      bit  up, dn, busy, en, stb_low, fall;
      d  = (ph_index(hist[1][1:0]) - ph_index(hist[2][1:0]) + 4) % 4;
      up = (d == 1);
      dn = (d == 3);
      stb_low = !hist[1][2];
      fall    = hist[2][2] && !hist[1][2];
      busy = up || dn || (m_settle > 0);
      en   = (m_pend || stb_low) && !busy;
      if (en) m_snap = m_cnt;
      m_pend   = (m_pend || fall) && !en;
      m_settle = (up || dn) ? SETTLE : ((m_settle > 0) ? m_settle - 1 : 0);
      m_carry  = up && (m_cnt == 255);
      m_borrow = dn && (m_cnt == 0);
      if (d == 2) m_err = 1;
      if (up) begin m_cnt = (m_cnt + 1) % 256; m_dir = 1; end
      if (dn) begin m_cnt = (m_cnt + 255) % 256; m_dir = 0; end
      seen[m_cnt] = 1;
      hist.push_front({stbn, qa, qb});
      void'(hist.pop_back());
    end
  end

  // per-cycle comparison, away from the active edge
  logic [CW-1:0] last_snap = '0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(snap == CW'(m_snap), "R7 snapshot vs model", snap, m_snap);
      chk(dir == m_dir, "R6 direction vs model", dir, m_dir);
      chk(carry == m_carry, "R4 carry vs model", carry, m_carry);
      chk(borrow == m_borrow, "R5 borrow vs model", borrow, m_borrow);
      chk(perr == m_err, "R3 error vs model", perr, m_err);
      if (snap != last_snap)
        chk(seen.exists(int'(snap)), "R8 snapshot is a real count", snap, m_cnt);
      if (carry) carry_seen = 1;
      if (borrow) borrow_seen = 1;
      last_snap = snap;
    end else begin
      last_snap = '0;
    end
  end

  // ---------------- stimulus ----------------
  int ph;      // phase position 0..3 in order 00,10,11,01
  int exp_cnt; // independent step tally

  task automatic drive_ph();
    case (ph)
      0: {qa, qb} = 2'b00;
      1: {qa, qb} = 2'b10;
      2: {qa, qb} = 2'b11;
      default: {qa, qb} = 2'b01;
    endcase
  endtask

  task automatic step(input bit up_dir, input int gap);
    ph = up_dir ? (ph + 1) % 4 : (ph + 3) % 4;
    exp_cnt = up_dir ? (exp_cnt + 1) % 256 : (exp_cnt + 255) % 256;
    drive_ph();
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; qa = 1'b0; qb = 1'b0; stbn = 1'b1;
    ph = 0; exp_cnt = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(negedge clk);
        chk(1'b0, "R1 watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    join_none

    model_reset();
    carry_seen = 0; borrow_seen = 0;
    do_reset();
    chk(snap == 0, "R11 snapshot after reset", snap, 0);
    chk(dir == 1'b1, "R11 direction after reset", dir, 1);
    chk(perr == 1'b0, "R11 error after reset", perr, 0);

    // forward steps with the strobe held low
    stbn = 1'b0;
    for (int i = 0; i < 6; i++) step(1'b1, 6);
    chk(snap == 6, "R1 six forward steps", snap, 6);
    chk(snap == CW'(exp_cnt), "R2 forward counts up", snap, exp_cnt);
    chk(dir == 1'b1, "R6 direction up", dir, 1);

    // reverse through zero
    for (int i = 0; i < 10; i++) step(1'b0, 6);
    chk(snap == 252, "R2 reverse counts down", snap, 252);
    chk(borrow_seen, "R5 borrow pulse on down wrap", borrow_seen, 1);
    chk(dir == 1'b0, "R6 direction down", dir, 0);

    // forward back through 255
    for (int i = 0; i < 4; i++) step(1'b1, 6);
    chk(snap == 0, "R4 up wrap to zero", snap, 0);
    chk(carry_seen, "R4 carry pulse on up wrap", carry_seen, 1);

    // illegal double change
    {qa, qb} = ~{qa, qb};
    ph = (ph + 2) % 4;
    repeat (8) @(negedge clk);
    chk(perr == 1'b1, "R3 error set", perr, 1);
    chk(snap == 0, "R3 no count on double change", snap, 0);
    step(1'b1, 6);
    step(1'b1, 6);
    chk(perr == 1'b1, "R3 error is sticky", perr, 1);
    chk(snap == CW'(exp_cnt), "R1 counting resumes", snap, exp_cnt);

    // latency of a phase change: visible after the third edge
    step(1'b0, 2);
    chk(dir == 1'b1, "R10 no change after two edges", dir, 1);
    @(negedge clk);
    chk(dir == 1'b0, "R10 change after three edges", dir, 0);
    repeat (6) @(negedge clk);

    // strobe high: snapshot holds
    stbn = 1'b1;
    repeat (4) @(negedge clk);
    begin
      int held;
      held = snap;
      for (int i = 0; i < 3; i++) step(1'b1, 6);
      chk(snap == CW'(held), "R7 held while strobe high", snap, held);
    end

    // strobe pulses placed around a step
    for (int off = -3; off <= 5; off++) begin
      if (off < 0) begin
        repeat (-off) @(negedge clk);
      end
      stbn = (off < 0) ? 1'b0 : 1'b1;
      if (off < 0) begin
        @(negedge clk);
        stbn = 1'b1;
      end
      step(1'b1, (off >= 0) ? off : 0);
      if (off >= 0) begin
        stbn = 1'b0;
        @(negedge clk);
        stbn = 1'b1;
      end
      repeat (10) @(negedge clk);
      chk(snap == CW'(m_snap), "R8 strobe near a step", snap, m_snap);
    end

    // single-cycle strobe that falls in the busy window
    stbn = 1'b0;
    step(1'b0, 1);
    stbn = 1'b1;
    repeat (10) @(negedge clk);
    chk(snap == CW'(exp_cnt), "R9 pending request served after settle", snap, exp_cnt);

    // reset mid-run
    stbn = 1'b0;
    step(1'b1, 6);
    do_reset();
    chk(snap == 0, "R11 snapshot cleared", snap, 0);
    chk(perr == 1'b0, "R11 error cleared", perr, 0);
    chk(dir == 1'b1, "R11 direction set up", dir, 1);
    repeat (6) @(negedge clk);
    chk(snap == 0, "R11 no pending request survives", snap, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule